// File: doc/BRIEF.md
# Seconds Real-Time Counter with Alarm

This block is a free-running real-time counter meant to be clocked by a 32.768 kHz low-power tick. It holds one 47-bit count. Software sees that count as two words: a 32-bit word of whole seconds and a 15-bit word holding the fraction of a second. A second word pair holds an alarm time that is compared at one-second resolution. A match raises a sticky alarm flag, and that flag can drive an interrupt line. Software reaches every register through a simple memory-mapped read/write port. The bus clock is `clk`, and each count step is qualified by `tick_i`.

The counter steps only while three things hold: it is enabled, it is not held by the non-valid or failure inputs, and it has not overflowed. A run-state machine decides whether the counter may step, using four states:
- ST_IDLE: enable bit clear.
- ST_RUN: counting.
- ST_HALT: held by `nonvalid_i` or `failed_i`.
- ST_OVF: overflow flag set.

Every cycle the machine takes the transition whose condition has the highest priority:
- Overflow entry: to ST_OVF while the overflow flag is set.
- Hold entry: to ST_HALT while either hold input is high.
- Stop: to ST_IDLE when the enable bit is clear.
- Start/resume: to ST_RUN otherwise.

Writing the seconds word loads the count and sets the enable bit, so that one write both loads and restarts the counter. Two lock bits freeze the counter against software writes, and a write-pending input stands in for the slow cross-domain write path.

Top module: `sec_rtc`

## Requirements
- R1: After reset, the registers read as follows: seconds (0x00) = 0, fraction (0x04) = 0, alarm seconds (0x08) = 0xFFFFFFFF, control (0x10) = 0, status (0x14) = hold inputs only, interrupt enable (0x18) = 0. `irq_o` is low.
- R2: In ST_RUN, each cycle with `tick_i` high adds one to the 47-bit count. The fraction reads at 0x04 bits 14:0, and a carry out of the fraction increments the seconds at 0x00.
- R3: Writing 0x00 loads the seconds and sets control bit 3 (enable). Writing 0x04 loads the fraction. A load takes priority over a tick in the same cycle.
- R4: The counter does not step while any of these holds: control bit 3 is clear, `nonvalid_i` is high, `failed_i` is high, or status bit 2 (overflow) is set. The run decision is registered, so a tick is gated by the conditions of the previous cycle.
- R5: A carry out of the top of the count wraps the count to zero and sets status bit 2. The count then stays frozen until software writes 1 to status bit 2.
- R6: The alarm seconds are written at 0x08. Only when the seconds roll over to a value equal to the alarm is status bit 4 (alarm flag) set, so one match sets it once. The alarm fraction word at 0x0C always reads 0, and writes to it are ignored.
- R7: An alarm value of 0xFFFFFFFF never sets the alarm flag.
- R8: Writing 1 to status bit 4 clears the alarm flag. A match in the same cycle wins over the clear.
- R9: `irq_o` is high exactly while the alarm flag and interrupt-enable bit 4 (0x18) are both set, with no added latency.
- R10: Control bits 17 (soft lock) and 18 (hard lock) are set by writing 1 and stay set until reset. While either is set, writes to 0x00, 0x04 and control bit 3 are ignored.
- R11: While `wr_busy_i` is high, every register write is ignored except writes to the interrupt enable at 0x18.
- R12: Status bit 1 reflects `nonvalid_i` and status bit 0 reflects `failed_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 32.768 kHz count qualifier, one cycle per tick |
| nonvalid_i | input | 1 | Non-valid condition, holds the counter |
| failed_i | input | 1 | Failure condition, holds the counter |
| wr_busy_i | input | 1 | A low-power-domain write is still pending |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Alarm interrupt |

## Verification
Register writes appear on a read one clock after the strobe, and `irq_o` follows the flag and enable registers in that same cycle. A change to enable, a hold input or the overflow flag reaches the step gate only two edges later, because the run decision is itself a register. The behavioural model in the bench registers that decision the same way and is compared against the read data and `irq_o` shortly after every rising edge. The directed checks read at least one cycle after the last write or tick they depend on, so the two-edge start-up lag of the seconds write is always counted.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int OFS_SEC    = 'h00;
    localparam int OFS_FRAC   = 'h04;
    localparam int OFS_ASEC   = 'h08;
    localparam int OFS_AFRAC  = 'h0C;
    localparam int OFS_CTRL   = 'h10;
    localparam int OFS_STAT   = 'h14;
    localparam int OFS_IEN    = 'h18;

    localparam int CTL_EN_BIT    = 3;
    localparam int CTL_SLOCK_BIT = 17;
    localparam int CTL_HLOCK_BIT = 18;
    localparam int STS_FAIL_BIT  = 0;
    localparam int STS_NV_BIT    = 1;
    localparam int STS_OVF_BIT   = 2;
    localparam int STS_ALM_BIT   = 4;
    localparam int IEN_ALM_BIT   = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2,
        ST_OVF  = 2'd3
    } run_state_e;
endpackage

// File: rtl/rtc_fsm.sv
module rtc_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hold,
    input  logic ovf,
    output logic run
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ovf)       state_d = ST_OVF;
                else if (hold) state_d = ST_HALT;
                else if (en)   state_d = ST_RUN;
            end
            ST_RUN: begin
                if (ovf)       state_d = ST_OVF;
                else if (hold) state_d = ST_HALT;
                else if (!en)  state_d = ST_IDLE;
            end
            ST_HALT: begin
                if (ovf)       state_d = ST_OVF;
                else if (!hold) state_d = en ? ST_RUN : ST_IDLE;
            end
            ST_OVF: begin
                if (!ovf) state_d = hold ? ST_HALT : (en ? ST_RUN : ST_IDLE);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              ld_sec,
    input  logic              ld_frac,
    input  logic [SEC_W-1:0]  wdata,
    output logic [SEC_W-1:0]  sec,
    output logic [FRAC_W-1:0] frac,
    output logic [SEC_W-1:0]  sec_next,
    output logic              rollover,
    output logic              wrap
);
    localparam int CNT_W = SEC_W + FRAC_W;

    logic [CNT_W-1:0] cnt_q;
    logic             step;

    assign step     = run & tick & ~ld_sec & ~ld_frac;
    assign rollover = step & (&cnt_q[FRAC_W-1:0]);
    assign wrap     = step & (&cnt_q);
    assign sec      = cnt_q[CNT_W-1:FRAC_W];
    assign frac     = cnt_q[FRAC_W-1:0];
    assign sec_next = sec + SEC_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (ld_sec)  cnt_q[CNT_W-1:FRAC_W] <= wdata;
        else if (ld_frac) cnt_q[FRAC_W-1:0] <= wdata[FRAC_W-1:0];
        else if (step)    cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rollover,
    input  logic [SEC_W-1:0] sec_next,
    input  logic [SEC_W-1:0] alarm_sec,
    input  logic             clr,
    output logic             flag
);
    logic hit;

    assign hit = rollover & (sec_next == alarm_sec) & ~(&alarm_sec);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= hit | (flag & ~clr);
    end
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              nonvalid_i,
    input  logic              failed_i,
    input  logic              wr_busy_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam int SEC_W = DATA_W;
    localparam logic [ADDR_W-1:0] A_SEC   = ADDR_W'(OFS_SEC);
    localparam logic [ADDR_W-1:0] A_FRAC  = ADDR_W'(OFS_FRAC);
    localparam logic [ADDR_W-1:0] A_ASEC  = ADDR_W'(OFS_ASEC);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFS_IEN);

    logic              en_q, slock_q, hlock_q, ie_q, ovf_q;
    logic [SEC_W-1:0]  alarm_q;
    logic              wr_ok, locked, cnt_wr, ld_sec, ld_frac, ld_any;
    logic              fsm_run, cnt_run, alm_clr, ovf_clr, caf;
    logic [SEC_W-1:0]  sec, sec_next;
    logic [FRAC_W-1:0] frac;
    logic              rollover, wrap;

    assign wr_ok   = bus_wr_i & ~wr_busy_i;
    assign locked  = slock_q | hlock_q;
    assign cnt_wr  = wr_ok & ~locked;
    assign ld_sec  = cnt_wr & (bus_addr_i == A_SEC);
    assign ld_frac = cnt_wr & (bus_addr_i == A_FRAC);
    assign ld_any  = ld_sec | ld_frac;
    assign alm_clr = wr_ok & (bus_addr_i == A_STAT) & bus_wdata_i[STS_ALM_BIT];
    assign ovf_clr = wr_ok & (bus_addr_i == A_STAT) & bus_wdata_i[STS_OVF_BIT];
    assign cnt_run = fsm_run & ~ovf_q;

    rtc_fsm u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en_q),
        .hold (nonvalid_i | failed_i),
        .ovf  (ovf_q),
        .run  (fsm_run)
    );

    rtc_counter #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cnt_run),
        .tick    (tick_i),
        .ld_sec  (ld_sec),
        .ld_frac (ld_frac),
        .wdata   (bus_wdata_i),
        .sec     (sec),
        .frac    (frac),
        .sec_next(sec_next),
        .rollover(rollover),
        .wrap    (wrap)
    );

    rtc_alarm #(.SEC_W(SEC_W)) u_alm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rollover (rollover),
        .sec_next (sec_next),
        .alarm_sec(alarm_q),
        .clr      (alm_clr),
        .flag     (caf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            slock_q <= 1'b0;
            hlock_q <= 1'b0;
            ie_q    <= 1'b0;
            ovf_q   <= 1'b0;
            alarm_q <= '1;
        end else begin
            ovf_q <= wrap | (ovf_q & ~ovf_clr);
            if (ld_sec)
                en_q <= 1'b1;
            else if (cnt_wr && bus_addr_i == A_CTRL)
                en_q <= bus_wdata_i[CTL_EN_BIT];
            if (wr_ok && bus_addr_i == A_CTRL) begin
                slock_q <= slock_q | bus_wdata_i[CTL_SLOCK_BIT];
                hlock_q <= hlock_q | bus_wdata_i[CTL_HLOCK_BIT];
            end
            if (wr_ok && bus_addr_i == A_ASEC)
                alarm_q <= bus_wdata_i;
            if (bus_wr_i && bus_addr_i == A_IEN)
                ie_q <= bus_wdata_i[IEN_ALM_BIT];
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_SEC:  bus_rdata_o = sec;
            A_FRAC: bus_rdata_o[FRAC_W-1:0] = frac;
            A_ASEC: bus_rdata_o = alarm_q;
            A_CTRL: begin
                bus_rdata_o[CTL_EN_BIT]    = en_q;
                bus_rdata_o[CTL_SLOCK_BIT] = slock_q;
                bus_rdata_o[CTL_HLOCK_BIT] = hlock_q;
            end
            A_STAT: begin
                bus_rdata_o[STS_ALM_BIT]  = caf;
                bus_rdata_o[STS_OVF_BIT]  = ovf_q;
                bus_rdata_o[STS_NV_BIT]   = nonvalid_i;
                bus_rdata_o[STS_FAIL_BIT] = failed_i;
            end
            A_IEN:  bus_rdata_o[IEN_ALM_BIT] = ie_q;
            default: bus_rdata_o = '0;
        endcase
    end

    assign irq_o = caf & ie_q;
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_busy_i,
    input logic              run,
    input logic              ovf_q,
    input logic              ld_any,
    input logic [SEC_W-1:0]  sec,
    input logic [FRAC_W-1:0] frac,
    input logic              slock_q,
    input logic              hlock_q,
    input logic [SEC_W-1:0]  alarm_q,
    input logic              caf,
    input logic              rollover
);
    AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_any) |=> $stable({sec, frac})); // R4
    AST_OVF_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ld_any) |=> $stable({sec, frac})); // R5
    AST_OVF_WRAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> (sec == '0 && frac == '0)); // R5
    AST_SLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        slock_q |=> slock_q); // R10
    AST_HLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hlock_q |=> hlock_q); // R10
    AST_BUSY_KEEPS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy_i |=> $stable(alarm_q)); // R11
    AST_ALARM_ON_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(caf) |-> $past(rollover)); // R6
    AST_ALARM_NOT_UNSET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(caf) |-> $past(alarm_q) != '1); // R7
endmodule

bind sec_rtc rtc_chk #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_busy_i(wr_busy_i),
    .run      (cnt_run),
    .ovf_q    (ovf_q),
    .ld_any   (ld_any),
    .sec      (sec),
    .frac     (frac),
    .slock_q  (slock_q),
    .hlock_q  (hlock_q),
    .alarm_q  (alarm_q),
    .caf      (caf),
    .rollover (rollover)
);

// File: tb/sec_rtc_test.sv
module sec_rtc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0, nonvalid_i = 1'b0, failed_i = 1'b0, wr_busy_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [4:0]  bus_addr_i = 5'h0;
    logic [31:0] bus_wdata_i = 32'h0;
    logic [31:0] bus_rdata_o;
    logic        irq_o;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    sec_rtc uut (.*);

    always #4 clk = ~clk;

    // behavioural reference model
    longint      m_cnt;
    logic [31:0] m_alarm;
    bit m_en, m_soft, m_hard, m_ie, m_caf, m_ovf, m_run;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_alarm = 32'hFFFF_FFFF;
            m_en = 0; m_soft = 0; m_hard = 0; m_ie = 0; m_caf = 0; m_ovf = 0; m_run = 0;
        end else begin
            bit wok, cw, ldsec, ldfrac, step, nrun, hit, wrapv, c_alm, c_ovf;
            wok    = bus_wr_i && !wr_busy_i;
            cw     = wok && !(m_soft || m_hard);
            ldsec  = cw && bus_addr_i == 5'h00;
            ldfrac = cw && bus_addr_i == 5'h04;
            step   = m_run && !m_ovf && tick_i && !ldsec && !ldfrac;
            nrun   = m_en && !nonvalid_i && !failed_i && !m_ovf;
            c_alm  = wok && bus_addr_i == 5'h14 && bus_wdata_i[4];
            c_ovf  = wok && bus_addr_i == 5'h14 && bus_wdata_i[2];
            hit = 0; wrapv = 0;
            if (ldsec) m_cnt = (longint'(bus_wdata_i) << 15) | (m_cnt & 64'h7FFF);
            else if (ldfrac) m_cnt = (m_cnt & ~64'h7FFF) | longint'(bus_wdata_i & 32'h7FFF);
            else if (step) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == 64'h8000_0000_0000) begin m_cnt = 0; wrapv = 1; end
                if ((m_cnt & 64'h7FFF) == 0 && m_alarm != 32'hFFFF_FFFF &&
                    (m_cnt >> 15) == longint'(m_alarm)) hit = 1;
            end
            m_caf = hit || (m_caf && !c_alm);
            m_ovf = wrapv || (m_ovf && !c_ovf);
            if (ldsec) m_en = 1;
            else if (cw && bus_addr_i == 5'h10) m_en = bus_wdata_i[3];
            if (wok && bus_addr_i == 5'h10) begin
                m_soft = m_soft || bus_wdata_i[17];
                m_hard = m_hard || bus_wdata_i[18];
            end
            if (wok && bus_addr_i == 5'h08) m_alarm = bus_wdata_i;
            if (bus_wr_i && bus_addr_i == 5'h18) m_ie = bus_wdata_i[4];
            m_run = nrun;
        end
    end

    function automatic logic [31:0] exp_rd(logic [4:0] a);
        logic [31:0] v = 32'h0;
        case (a)
            5'h00: v = 32'(m_cnt >> 15);
            5'h04: v = 32'(m_cnt & 64'h7FFF);
            5'h08: v = m_alarm;
            5'h10: begin v[3] = m_en; v[17] = m_soft; v[18] = m_hard; end
            5'h14: begin v[4] = m_caf; v[2] = m_ovf; v[1] = nonvalid_i; v[0] = failed_i; end
            5'h18: v[4] = m_ie;
            default: v = 32'h0;
        endcase
        return v;
    endfunction

    function automatic string tag_of(logic [4:0] a);
        case (a)
            5'h00, 5'h04: return "R2";
            5'h08, 5'h0C: return "R6";
            5'h10: return "R10";
            5'h14: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk(tag_of(bus_addr_i), bus_rdata_o, exp_rd(bus_addr_i));
            chk("R9 irq", {31'h0, irq_o}, {31'h0, m_caf && m_ie});
        end
    end

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk); bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk); bus_wr_i = 0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] v);
        @(negedge clk); bus_addr_i = a; #1; v = bus_rdata_o;
    endtask

    task automatic ticks(int n);
        @(negedge clk); tick_i = 1;
        repeat (n) @(negedge clk);
        tick_i = 0;
    endtask

    task automatic pulse_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v, a0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        rd(5'h00, v); chk("R1 sec", v, 32'h0);
        rd(5'h04, v); chk("R1 frac", v, 32'h0);
        rd(5'h08, v); chk("R1 alarm", v, 32'hFFFF_FFFF);
        rd(5'h10, v); chk("R1 ctrl", v, 32'h0);
        rd(5'h14, v); chk("R1 status", v, 32'h0);
        rd(5'h18, v); chk("R1 ien", v, 32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);
        // R3 loads
        wr(5'h04, 32'h7FF0); wr(5'h00, 32'd5);
        rd(5'h00, v); chk("R3 sec", v, 32'd5);
        rd(5'h04, v); chk("R3 frac", v, 32'h7FF0);
        rd(5'h10, v); chk("R3 enable", v, 32'h8);
        // R2 counting with carry
        ticks(40);
        rd(5'h00, v); chk("R2 sec carry", v, 32'd6);
        rd(5'h04, v); chk("R2 frac", v, 32'h18);
        // R6 alarm match on rollover, R9 irq
        wr(5'h08, 32'd7); wr(5'h18, 32'h10);
        wr(5'h04, 32'h7FF0); wr(5'h00, 32'd6);
        ticks(40);
        rd(5'h14, v); chk("R6 flag", v, 32'h10);
        chk("R9 irq high", {31'h0, irq_o}, 32'h1);
        wr(5'h18, 32'h0);
        rd(5'h14, v); chk("R9 irq masked", {31'h0, irq_o}, 32'h0);
        wr(5'h18, 32'h10);
        // R8 clear
        wr(5'h14, 32'h10);
        rd(5'h14, v); chk("R8 cleared", v, 32'h0);
        ticks(40);
        rd(5'h14, v); chk("R6 once only", v, 32'h0);
        wr(5'h0C, 32'h1234);
        rd(5'h0C, v); chk("R6 alarm fraction", v, 32'h0);
        // R4 halt conditions
        wr(5'h10, 32'h0);
        rd(5'h04, a0); ticks(20); rd(5'h04, v); chk("R4 enable clear", v, a0);
        @(negedge clk); nonvalid_i = 1;
        wr(5'h10, 32'h8);
        rd(5'h14, v); chk("R12 nonvalid", v, 32'h2);
        rd(5'h04, a0); ticks(20); rd(5'h04, v); chk("R4 nonvalid", v, a0);
        @(negedge clk); nonvalid_i = 0; failed_i = 1;
        rd(5'h14, v); chk("R12 failed", v, 32'h1);
        rd(5'h04, a0); ticks(20); rd(5'h04, v); chk("R4 failed", v, a0);
        @(negedge clk); failed_i = 0;
        rd(5'h04, a0); ticks(5); rd(5'h04, v); chk("R4 resume", v, a0 + 32'd5);
        // R11 write pending
        @(negedge clk); wr_busy_i = 1;
        wr(5'h00, 32'h123); wr(5'h18, 32'h0);
        rd(5'h00, v); chk("R11 sec kept", v, 32'd7);
        rd(5'h18, v); chk("R11 ien taken", v, 32'h0);
        @(negedge clk); wr_busy_i = 0;
        // R10 locks
        wr(5'h10, 32'h0002_0008); wr(5'h00, 32'h55);
        rd(5'h00, v); chk("R10 soft lock", v, 32'd7);
        wr(5'h10, 32'h0);
        rd(5'h10, v); chk("R10 sticky", v, 32'h0002_0008);
        pulse_reset();
        rd(5'h10, v); chk("R1 locks cleared", v, 32'h0);
        wr(5'h10, 32'h0004_0000); wr(5'h04, 32'h100);
        rd(5'h04, v); chk("R10 hard lock", v, 32'h0);
        pulse_reset();
        // R7 unset alarm, then R5 overflow
        wr(5'h04, 32'h7FFD); wr(5'h00, 32'hFFFF_FFFE);
        ticks(6);
        rd(5'h00, v); chk("R7 sec", v, 32'hFFFF_FFFF);
        rd(5'h14, v); chk("R7 no flag", v, 32'h0);
        ticks(32800);
        rd(5'h00, v); chk("R5 sec wrap", v, 32'h0);
        rd(5'h04, v); chk("R5 frac frozen", v, 32'h0);
        rd(5'h14, v); chk("R5 ovf flag", v, 32'h4);
        wr(5'h14, 32'h4);
        ticks(10);
        rd(5'h04, v); chk("R5 resume", v, 32'd10);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule